// File: doc/BRIEF.md
# Home Directory Coherence Engine

This block sits at the home node of a flat, memory-held directory. It takes coherence requests for the lines it is home to, one at a time: read, read-exclusive, upgrade and writeback from caches, plus the revision messages an owner sends back after an intervention (sharing writeback, downgrade, ownership transfer). For each accepted request it looks up and rewrites the line's directory entry, then emits the replies, NACKs, interventions and invalidations that the request calls for on a single message-out channel, one message per cycle.

The engine never queues requests behind an unfinished transaction. While a line waits for an owner to answer an intervention it sits in a transient busy state and every new demand request is refused with a NACK. A writeback that crosses an intervention on the way to the home is merged into the waiting transaction: the written-back data goes straight to the pending requestor and the writer gets its ack. A speculative memory read is launched in the cycle a read or read-exclusive is accepted, alongside the directory lookup, so that data is ready one cycle after the lookup decides what to send.

Top module: `dir_home_engine`

## Requirements
- R1: After reset every line is unowned, `req_ready_o` is 1 and `msg_valid_o` is 0; the first read of any line is answered with exclusive data (message code 2).
- R2: A read (request code 0), read-exclusive (code 1) or upgrade (code 2) to a line in a busy state is answered with a single NACK (message code 0) to the requestor and leaves the entry unchanged.
- R3: A read to an unowned line makes the requestor the exclusive owner and replies with exclusive data (code 2); a read to a shared line adds the requestor to the sharers and replies with shared data (code 1); both carry the memory word of the line.
- R4: A read or read-exclusive to an exclusive line owned by another node moves the line to busy-shared or busy-exclusive respectively, records the requestor as pending, sends speculative data (code 3) to the requestor and then an intervention (code 5 for shared, code 6 for exclusive) to the owner with `msg_req_o` naming the requestor.
- R5: An upgrade to an unowned or exclusive line is NACKed (code 0).
- R6: A read-exclusive or upgrade to a shared line makes the requestor the exclusive owner; the reply (code 2 with data, or code 4 without) carries in `msg_cnt_o` the number of other sharers, and one invalidation (code 7) goes to each other sharer in ascending node order with `msg_req_o` naming the requestor; the requestor itself is never invalidated.
- R7: A writeback (request code 3) from the owner of an exclusive line makes the line unowned, pulses `mem_wr_o` with the written data, and returns a writeback ack (code 8); any other writeback to a non-busy line is NACKed and writes no memory.
- R8: A writeback to a busy-shared line makes it shared by the pending requestor only; to a busy-exclusive line makes the pending requestor the exclusive owner; in both cases the written data is forwarded to the pending requestor (code 1 or code 2) followed by a writeback ack (code 8) to the writer.
- R9: A sharing writeback (code 4) or downgrade (code 5) makes a busy-shared line shared by both the pending requestor and the old owner; an ownership transfer (code 6) makes a busy-exclusive line exclusive to the pending requestor; none of these emits a message, and only the sharing writeback writes memory.
- R10: A poison mark (request code 7) puts a line in the poisoned state; thereafter any read, read-exclusive, upgrade or writeback to it gets a poison error reply (code 9) and the line stays poisoned.
- R11: `mem_rd_o` is asserted with `mem_line_o` equal to the request line in the acceptance cycle of every read and read-exclusive; memory data is taken one cycle later and the first outgoing message appears in the second cycle after acceptance.
- R12: Messages for one request leave in the order reply, second message, invalidations, one per cycle; `req_ready_o` stays low from acceptance until the last message has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine can accept a request |
| req_kind_i | input | 3 | Request code |
| req_src_i | input | NW | Sending node |
| req_line_i | input | LW | Line index |
| req_data_i | input | DW | Writeback data |
| mem_rd_o | output | 1 | Speculative memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_line_o | output | LW | Memory line index |
| mem_wdata_o | output | DW | Memory write data |
| mem_data_i | input | DW | Memory read data, valid one cycle after `mem_rd_o` |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_kind_o | output | 4 | Message code |
| msg_dst_o | output | NW | Destination node |
| msg_req_o | output | NW | Requestor the message acts for |
| msg_cnt_o | output | NW+1 | Pending invalidation count |
| msg_line_o | output | LW | Line index |
| msg_data_o | output | DW | Line data (zero for data-less codes) |

## Verification
The hardest situation to reach is the crossing writeback: the line must first be made exclusive by one node, then a second node's read or read-exclusive must turn it busy and trigger an intervention, and only then must the old owner's writeback arrive while the intervention is notionally still in flight. The stimulus builds this deliberately on separate lines for the busy-shared and busy-exclusive cases, then probes the resulting state with a further request whose reply and invalidation count only come out right if the merge recorded the correct owner or sharers.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    ST_UN = 3'd0, ST_SH = 3'd1, ST_EX = 3'd2,
    ST_BUSY_UN = 3'd3, ST_BUSY_SH = 3'd4, ST_BUSY_EX = 3'd5,
    ST_PSN = 3'd6
  } dir_st_e;

  typedef enum logic [2:0] {
    RQ_READ = 3'd0, RQ_RDEX = 3'd1, RQ_UPG = 3'd2, RQ_WB = 3'd3,
    RQ_SHWB = 3'd4, RQ_DNGR = 3'd5, RQ_XFER = 3'd6, RQ_MARK = 3'd7
  } req_kind_e;

  typedef enum logic [3:0] {
    MS_NACK = 4'd0, MS_DATA_SH = 4'd1, MS_DATA_EX = 4'd2, MS_SPEC = 4'd3,
    MS_UPG_ACK = 4'd4, MS_INTV_SH = 4'd5, MS_INTV_EX = 4'd6, MS_INVAL = 4'd7,
    MS_WB_ACK = 4'd8, MS_PSN_ERR = 4'd9
  } msg_kind_e;

  function automatic logic st_busy(dir_st_e s);
    return (s == ST_BUSY_UN) || (s == ST_BUSY_SH) || (s == ST_BUSY_EX);
  endfunction

  function automatic logic msg_has_data(msg_kind_e k);
    return (k == MS_DATA_SH) || (k == MS_DATA_EX) || (k == MS_SPEC);
  endfunction
endpackage

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_NODES = 8,
  parameter int LW = $clog2(NUM_LINES),
  parameter int NW = $clog2(NUM_NODES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LW-1:0]        rd_line_i,
  output dir_st_e              rd_st_o,
  output logic [NUM_NODES-1:0] rd_vec_o,
  output logic [NW-1:0]        rd_own_o,
  output logic [NW-1:0]        rd_pnd_o,
  input  logic                 wr_en_i,
  input  logic [LW-1:0]        wr_line_i,
  input  dir_st_e              wr_st_i,
  input  logic [NUM_NODES-1:0] wr_vec_i,
  input  logic [NW-1:0]        wr_own_i,
  input  logic [NW-1:0]        wr_pnd_i
);
  dir_st_e              st_q  [NUM_LINES];
  logic [NUM_NODES-1:0] vec_q [NUM_LINES];
  logic [NW-1:0]        own_q [NUM_LINES];
  logic [NW-1:0]        pnd_q [NUM_LINES];

  assign rd_st_o  = st_q[rd_line_i];
  assign rd_vec_o = vec_q[rd_line_i];
  assign rd_own_o = own_q[rd_line_i];
  assign rd_pnd_o = pnd_q[rd_line_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        st_q[i]  <= ST_UN;
        vec_q[i] <= '0;
        own_q[i] <= '0;
        pnd_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      st_q[wr_line_i]  <= wr_st_i;
      vec_q[wr_line_i] <= wr_vec_i;
      own_q[wr_line_i] <= wr_own_i;
      pnd_q[wr_line_i] <= wr_pnd_i;
    end
  end

  AST_PSN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && st_q[wr_line_i] == ST_PSN) |-> (wr_st_i == ST_PSN)); // R10
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
#(
  parameter int NUM_NODES = 8,
  parameter int NW = $clog2(NUM_NODES)
) (
  input  req_kind_e            kind_i,
  input  logic [NW-1:0]        src_i,
  input  dir_st_e              st_i,
  input  logic [NUM_NODES-1:0] vec_i,
  input  logic [NW-1:0]        own_i,
  input  logic [NW-1:0]        pnd_i,
  output dir_st_e              nxt_st_o,
  output logic [NUM_NODES-1:0] nxt_vec_o,
  output logic [NW-1:0]        nxt_own_o,
  output logic [NW-1:0]        nxt_pnd_o,
  output logic                 mem_wr_o,
  output logic                 rpl_en_o,
  output msg_kind_e            rpl_kind_o,
  output logic [NW-1:0]        rpl_dst_o,
  output logic [NW:0]          rpl_cnt_o,
  output logic                 rpl_wb_o,
  output logic                 x_en_o,
  output msg_kind_e            x_kind_o,
  output logic [NW-1:0]        x_dst_o,
  output logic [NW-1:0]        x_req_o,
  output logic [NUM_NODES-1:0] inv_mask_o
);
  localparam int CW = NW + 1;

  logic [NUM_NODES-1:0] src_bit, pnd_bit, others;

  always_comb begin
    src_bit = '0;
    src_bit[src_i] = 1'b1;
    pnd_bit = '0;
    pnd_bit[pnd_i] = 1'b1;
    others = vec_i & ~src_bit;

    nxt_st_o   = st_i;
    nxt_vec_o  = vec_i;
    nxt_own_o  = own_i;
    nxt_pnd_o  = pnd_i;
    mem_wr_o   = 1'b0;
    rpl_en_o   = 1'b0;
    rpl_kind_o = MS_NACK;
    rpl_dst_o  = src_i;
    rpl_cnt_o  = '0;
    rpl_wb_o   = 1'b0;
    x_en_o     = 1'b0;
    x_kind_o   = MS_WB_ACK;
    x_dst_o    = src_i;
    x_req_o    = src_i;
    inv_mask_o = '0;

    if (kind_i == RQ_MARK) begin
      nxt_st_o  = ST_PSN;
      nxt_vec_o = '0;
    end else begin
      case (st_i)
        ST_PSN: begin
          if (kind_i inside {RQ_READ, RQ_RDEX, RQ_UPG, RQ_WB}) begin
            rpl_en_o   = 1'b1;
            rpl_kind_o = MS_PSN_ERR;
          end
        end
        ST_UN: begin
          if (kind_i inside {RQ_READ, RQ_RDEX}) begin
            nxt_st_o   = ST_EX;
            nxt_vec_o  = src_bit;
            nxt_own_o  = src_i;
            rpl_en_o   = 1'b1;
            rpl_kind_o = MS_DATA_EX;
          end else if (kind_i inside {RQ_UPG, RQ_WB}) begin
            rpl_en_o = 1'b1;
          end
        end
        ST_SH: begin
          if (kind_i == RQ_READ) begin
            nxt_vec_o  = vec_i | src_bit;
            rpl_en_o   = 1'b1;
            rpl_kind_o = MS_DATA_SH;
          end else if (kind_i inside {RQ_RDEX, RQ_UPG}) begin
            nxt_st_o   = ST_EX;
            nxt_vec_o  = src_bit;
            nxt_own_o  = src_i;
            rpl_en_o   = 1'b1;
            rpl_kind_o = (kind_i == RQ_RDEX) ? MS_DATA_EX : MS_UPG_ACK;
            rpl_cnt_o  = CW'($countones(others));
            inv_mask_o = others;
          end else if (kind_i == RQ_WB) begin
            rpl_en_o = 1'b1;
          end
        end
        ST_EX: begin
          if (kind_i inside {RQ_READ, RQ_RDEX}) begin
            rpl_en_o = 1'b1;
            if (own_i == src_i) begin
              rpl_kind_o = MS_DATA_EX;
            end else begin
              nxt_st_o   = (kind_i == RQ_READ) ? ST_BUSY_SH : ST_BUSY_EX;
              nxt_vec_o  = src_bit;
              nxt_pnd_o  = src_i;
              rpl_kind_o = MS_SPEC;
              x_en_o     = 1'b1;
              x_kind_o   = (kind_i == RQ_READ) ? MS_INTV_SH : MS_INTV_EX;
              x_dst_o    = own_i;
            end
          end else if (kind_i == RQ_UPG) begin
            rpl_en_o = 1'b1;
          end else if (kind_i == RQ_WB) begin
            rpl_en_o = 1'b1;
            if (own_i == src_i) begin
              nxt_st_o   = ST_UN;
              nxt_vec_o  = '0;
              mem_wr_o   = 1'b1;
              rpl_kind_o = MS_WB_ACK;
            end
          end
        end
        default: begin
          if (kind_i inside {RQ_READ, RQ_RDEX, RQ_UPG}) begin
            rpl_en_o = 1'b1;
          end else if (kind_i == RQ_WB) begin
            rpl_en_o = 1'b1;
            if (st_i inside {ST_BUSY_SH, ST_BUSY_EX}) begin
              // crossing writeback: merge into the pending transaction
              nxt_st_o   = (st_i == ST_BUSY_SH) ? ST_SH : ST_EX;
              nxt_vec_o  = pnd_bit;
              nxt_own_o  = pnd_i;
              mem_wr_o   = 1'b1;
              rpl_kind_o = (st_i == ST_BUSY_SH) ? MS_DATA_SH : MS_DATA_EX;
              rpl_dst_o  = pnd_i;
              rpl_wb_o   = 1'b1;
              x_en_o     = 1'b1;
            end
          end else if (kind_i inside {RQ_SHWB, RQ_DNGR}) begin
            if (st_i == ST_BUSY_SH) begin
              nxt_st_o  = ST_SH;
              nxt_vec_o = pnd_bit | src_bit;
              mem_wr_o  = (kind_i == RQ_SHWB);
            end
          end else if (kind_i == RQ_XFER) begin
            if (st_i == ST_BUSY_EX) begin
              nxt_st_o  = ST_EX;
              nxt_vec_o = pnd_bit;
              nxt_own_o = pnd_i;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dir_msg_seq.sv
module dir_msg_seq
  import dir_pkg::*;
#(
  parameter int NUM_NODES = 8,
  parameter int LW = 4,
  parameter int DW = 32,
  parameter int NW = $clog2(NUM_NODES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [LW-1:0]        line_i,
  input  logic [DW-1:0]        wb_data_i,
  input  logic                 rpl_en_i,
  input  msg_kind_e            rpl_kind_i,
  input  logic [NW-1:0]        rpl_dst_i,
  input  logic [NW:0]          rpl_cnt_i,
  input  logic                 rpl_wb_i,
  input  logic                 x_en_i,
  input  msg_kind_e            x_kind_i,
  input  logic [NW-1:0]        x_dst_i,
  input  logic [NW-1:0]        x_req_i,
  input  logic [NUM_NODES-1:0] inv_mask_i,
  input  logic [NW-1:0]        inv_req_i,
  input  logic [DW-1:0]        mem_data_i,
  output logic                 busy_o,
  output logic                 msg_valid_o,
  output msg_kind_e            msg_kind_o,
  output logic [NW-1:0]        msg_dst_o,
  output logic [NW-1:0]        msg_req_o,
  output logic [NW:0]          msg_cnt_o,
  output logic [LW-1:0]        msg_line_o,
  output logic [DW-1:0]        msg_data_o
);
  logic                 look_q, rpl_q, rpl_wb_q, x_q;
  msg_kind_e            rpl_kind_q, x_kind_q;
  logic [NW-1:0]        rpl_dst_q, x_dst_q, x_req_q, inv_req_q;
  logic [NW:0]          rpl_cnt_q;
  logic [NUM_NODES-1:0] inv_q;
  logic [LW-1:0]        line_q;
  logic [DW-1:0]        wbd_q, data_q;
  logic [NW-1:0]        inv_idx;

  always_comb begin
    inv_idx = '0;
    for (int i = NUM_NODES - 1; i >= 0; i--) begin
      if (inv_q[i]) inv_idx = NW'(i);
    end
  end

  assign busy_o      = look_q | rpl_q | x_q | (|inv_q);
  assign msg_valid_o = !look_q && (rpl_q || x_q || (|inv_q));
  assign msg_line_o  = line_q;

  always_comb begin
    if (rpl_q) begin
      msg_kind_o = rpl_kind_q;
      msg_dst_o  = rpl_dst_q;
      msg_req_o  = rpl_dst_q;
      msg_cnt_o  = rpl_cnt_q;
    end else if (x_q) begin
      msg_kind_o = x_kind_q;
      msg_dst_o  = x_dst_q;
      msg_req_o  = x_req_q;
      msg_cnt_o  = '0;
    end else begin
      msg_kind_o = MS_INVAL;
      msg_dst_o  = inv_idx;
      msg_req_o  = inv_req_q;
      msg_cnt_o  = '0;
    end
    msg_data_o = msg_has_data(msg_kind_o) ? data_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      look_q     <= 1'b0;
      rpl_q      <= 1'b0;
      rpl_wb_q   <= 1'b0;
      x_q        <= 1'b0;
      rpl_kind_q <= MS_NACK;
      x_kind_q   <= MS_NACK;
      rpl_dst_q  <= '0;
      x_dst_q    <= '0;
      x_req_q    <= '0;
      inv_req_q  <= '0;
      rpl_cnt_q  <= '0;
      inv_q      <= '0;
      line_q     <= '0;
      wbd_q      <= '0;
      data_q     <= '0;
    end else if (load_i) begin
      look_q     <= 1'b1;
      rpl_q      <= rpl_en_i;
      rpl_kind_q <= rpl_kind_i;
      rpl_dst_q  <= rpl_dst_i;
      rpl_cnt_q  <= rpl_cnt_i;
      rpl_wb_q   <= rpl_wb_i;
      x_q        <= x_en_i;
      x_kind_q   <= x_kind_i;
      x_dst_q    <= x_dst_i;
      x_req_q    <= x_req_i;
      inv_q      <= inv_mask_i;
      inv_req_q  <= inv_req_i;
      line_q     <= line_i;
      wbd_q      <= wb_data_i;
    end else if (look_q) begin
      // directory decided last cycle; memory word lands now
      look_q <= 1'b0;
      data_q <= rpl_wb_q ? wbd_q : mem_data_i;
    end else if (rpl_q) begin
      rpl_q <= 1'b0;
    end else if (x_q) begin
      x_q <= 1'b0;
    end else if (|inv_q) begin
      inv_q[inv_idx] <= 1'b0;
    end
  end

  AST_FIRST_MSG_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> !msg_valid_o); // R11
  AST_NO_SELF_INVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !inv_mask_i[inv_req_i]); // R6
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o); // R12
  AST_INVAL_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_kind_o == MS_INVAL) |=>
      ($countones(inv_q) + 1 == $countones($past(inv_q)))); // R12
endmodule

// File: rtl/dir_home_engine.sv
module dir_home_engine
  import dir_pkg::*;
#(
  parameter int NUM_NODES = 8,
  parameter int NUM_LINES = 16,
  parameter int DW = 32,
  parameter int NW = $clog2(NUM_NODES),
  parameter int LW = $clog2(NUM_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [2:0]    req_kind_i,
  input  logic [NW-1:0] req_src_i,
  input  logic [LW-1:0] req_line_i,
  input  logic [DW-1:0] req_data_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [LW-1:0] mem_line_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_data_i,
  output logic          msg_valid_o,
  output logic [3:0]    msg_kind_o,
  output logic [NW-1:0] msg_dst_o,
  output logic [NW-1:0] msg_req_o,
  output logic [NW:0]   msg_cnt_o,
  output logic [LW-1:0] msg_line_o,
  output logic [DW-1:0] msg_data_o
);
  req_kind_e            kind;
  logic                 accept, seq_busy, dec_mem_wr;
  dir_st_e              cur_st, nxt_st;
  logic [NUM_NODES-1:0] cur_vec, nxt_vec, inv_mask;
  logic [NW-1:0]        cur_own, cur_pnd, nxt_own, nxt_pnd;
  logic                 rpl_en, rpl_wb, x_en;
  msg_kind_e            rpl_kind, x_kind, out_kind;
  logic [NW-1:0]        rpl_dst, x_dst, x_req;
  logic [NW:0]          rpl_cnt;

  assign kind        = req_kind_e'(req_kind_i);
  assign req_ready_o = !seq_busy;
  assign accept      = req_valid_i && req_ready_o;
  assign mem_rd_o    = accept && (kind inside {RQ_READ, RQ_RDEX});
  assign mem_wr_o    = accept && dec_mem_wr;
  assign mem_line_o  = req_line_i;
  assign mem_wdata_o = req_data_i;
  assign msg_kind_o  = out_kind;

  dir_table #(.NUM_LINES(NUM_LINES), .NUM_NODES(NUM_NODES), .LW(LW), .NW(NW)) u_table (
    .clk_i, .rst_ni,
    .rd_line_i (req_line_i),
    .rd_st_o   (cur_st),
    .rd_vec_o  (cur_vec),
    .rd_own_o  (cur_own),
    .rd_pnd_o  (cur_pnd),
    .wr_en_i   (accept),
    .wr_line_i (req_line_i),
    .wr_st_i   (nxt_st),
    .wr_vec_i  (nxt_vec),
    .wr_own_i  (nxt_own),
    .wr_pnd_i  (nxt_pnd)
  );

  dir_decide #(.NUM_NODES(NUM_NODES), .NW(NW)) u_decide (
    .kind_i     (kind),
    .src_i      (req_src_i),
    .st_i       (cur_st),
    .vec_i      (cur_vec),
    .own_i      (cur_own),
    .pnd_i      (cur_pnd),
    .nxt_st_o   (nxt_st),
    .nxt_vec_o  (nxt_vec),
    .nxt_own_o  (nxt_own),
    .nxt_pnd_o  (nxt_pnd),
    .mem_wr_o   (dec_mem_wr),
    .rpl_en_o   (rpl_en),
    .rpl_kind_o (rpl_kind),
    .rpl_dst_o  (rpl_dst),
    .rpl_cnt_o  (rpl_cnt),
    .rpl_wb_o   (rpl_wb),
    .x_en_o     (x_en),
    .x_kind_o   (x_kind),
    .x_dst_o    (x_dst),
    .x_req_o    (x_req),
    .inv_mask_o (inv_mask)
  );

  dir_msg_seq #(.NUM_NODES(NUM_NODES), .LW(LW), .DW(DW), .NW(NW)) u_seq (
    .clk_i, .rst_ni,
    .load_i      (accept),
    .line_i      (req_line_i),
    .wb_data_i   (req_data_i),
    .rpl_en_i    (rpl_en),
    .rpl_kind_i  (rpl_kind),
    .rpl_dst_i   (rpl_dst),
    .rpl_cnt_i   (rpl_cnt),
    .rpl_wb_i    (rpl_wb),
    .x_en_i      (x_en),
    .x_kind_i    (x_kind),
    .x_dst_i     (x_dst),
    .x_req_i     (x_req),
    .inv_mask_i  (inv_mask),
    .inv_req_i   (req_src_i),
    .mem_data_i  (mem_data_i),
    .busy_o      (seq_busy),
    .msg_valid_o (msg_valid_o),
    .msg_kind_o  (out_kind),
    .msg_dst_o   (msg_dst_o),
    .msg_req_o   (msg_req_o),
    .msg_cnt_o   (msg_cnt_o),
    .msg_line_o  (msg_line_o),
    .msg_data_o  (msg_data_o)
  );

  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && st_busy(cur_st) && (kind inside {RQ_READ, RQ_RDEX, RQ_UPG})) |-> ##2
      (msg_valid_o && out_kind == MS_NACK && msg_dst_o == $past(req_src_i, 2))); // R2
  AST_POISON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cur_st == ST_PSN && (kind inside {RQ_READ, RQ_RDEX, RQ_UPG, RQ_WB})) |-> ##2
      (msg_valid_o && out_kind == MS_PSN_ERR)); // R10
  AST_MEM_RD_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !req_ready_o); // R11
endmodule

// File: tb/dir_home_engine_tb.sv
module dir_home_engine_tb;
  localparam int NW = 3;
  localparam int LW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_kind = '0;
  logic [NW-1:0] req_src = '0;
  logic [LW-1:0] req_line = '0;
  logic [DW-1:0] req_data = '0;
  logic          mem_rd, mem_wr;
  logic [LW-1:0] mem_line;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_data = '0;
  logic          msg_valid;
  logic [3:0]    msg_kind;
  logic [NW-1:0] msg_dst, msg_req;
  logic [NW:0]   msg_cnt;
  logic [LW-1:0] msg_line;
  logic [DW-1:0] msg_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  typedef struct packed {
    logic [3:0]    k;
    logic [NW-1:0] dst;
    logic [NW-1:0] rq;
    logic [NW:0]   cnt;
    logic [LW-1:0] line;
    logic [DW-1:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  dir_home_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_src_i(req_src), .req_line_i(req_line), .req_data_i(req_data),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_line_o(mem_line), .mem_wdata_o(mem_wdata),
    .mem_data_i(mem_data),
    .msg_valid_o(msg_valid), .msg_kind_o(msg_kind), .msg_dst_o(msg_dst), .msg_req_o(msg_req),
    .msg_cnt_o(msg_cnt), .msg_line_o(msg_line), .msg_data_o(msg_data)
  );

  // memory model: word of a line is D000_0000 | line, ready one cycle after the strobe
  always @(posedge clk) if (mem_rd) mem_data <= 32'hD000_0000 | 32'(mem_line);

  function automatic logic [DW-1:0] mword(input logic [LW-1:0] l);
    return 32'hD000_0000 | 32'(l);
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_msg(input logic [3:0] k, input logic [NW-1:0] dst, input logic [NW-1:0] rq,
                            input logic [NW:0] cnt, input logic [LW-1:0] line,
                            input logic [DW-1:0] data, input string tag);
    exp_q.push_back('{k: k, dst: dst, rq: rq, cnt: cnt, line: line, data: data});
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [2:0] k, input logic [NW-1:0] src, input logic [LW-1:0] line,
                      input logic [DW-1:0] data, input logic wr_exp, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = k;
    req_src   = src;
    req_line  = line;
    req_data  = data;
    #1;
    if (k == 3'd0 || k == 3'd1)
      check(mem_rd && mem_line == line, "R11", "spec read strobe/line",
            {mem_rd, 32'(mem_line)}, {1'b1, 32'(line)});
    if (k inside {3'd3, 3'd4, 3'd5, 3'd6})
      check(mem_wr == wr_exp && (!wr_exp || mem_wdata == data), tag, "memory write",
            {mem_wr, mem_wdata}, {wr_exp, data});
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check(!msg_valid, "R11", "message one cycle after accept", 64'(msg_valid), 64'd0);
    check(!req_ready, "R12", "ready low after accept", 64'(req_ready), 64'd0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && msg_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R12 unexpected message actual=%0h/%0h expected=none", msg_kind, msg_dst);
      end else begin
        exp_t  e;
        string t;
        logic  data_ok;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        data_ok = !(e.k inside {4'd1, 4'd2, 4'd3}) || (msg_data == e.data);
        n_chk++;
        if (!(msg_kind == e.k && msg_dst == e.dst && msg_req == e.rq && msg_cnt == e.cnt &&
              msg_line == e.line && data_ok)) begin
          n_bad++;
          $display("FAIL %s msg actual=k%0h d%0h r%0h c%0h l%0h %0h expected=k%0h d%0h r%0h c%0h l%0h %0h",
                   t, msg_kind, msg_dst, msg_req, msg_cnt, msg_line, msg_data,
                   e.k, e.dst, e.rq, e.cnt, e.line, e.data);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    check(msg_valid == 1'b0, "R1", "no message in reset", 64'(msg_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // line 1: unowned -> exclusive, busy NACKs, sharing writeback, shared reads, upgrade
    expect_msg(4'd2, 3'd2, 3'd2, 4'd0, 4'd1, mword(4'd1), "R1");
    send(3'd0, 3'd2, 4'd1, '0, 1'b0, "R3");
    expect_msg(4'd3, 3'd3, 3'd3, 4'd0, 4'd1, mword(4'd1), "R4");
    expect_msg(4'd5, 3'd2, 3'd3, 4'd0, 4'd1, '0, "R4");
    send(3'd0, 3'd3, 4'd1, '0, 1'b0, "R4");
    expect_msg(4'd0, 3'd4, 3'd4, 4'd0, 4'd1, '0, "R2");
    send(3'd0, 3'd4, 4'd1, '0, 1'b0, "R2");
    expect_msg(4'd0, 3'd5, 3'd5, 4'd0, 4'd1, '0, "R2");
    send(3'd1, 3'd5, 4'd1, '0, 1'b0, "R2");
    expect_msg(4'd0, 3'd5, 3'd5, 4'd0, 4'd1, '0, "R2");
    send(3'd2, 3'd5, 4'd1, '0, 1'b0, "R2");
    send(3'd4, 3'd2, 4'd1, 32'h1111, 1'b1, "R9");
    expect_msg(4'd1, 3'd6, 3'd6, 4'd0, 4'd1, mword(4'd1), "R3");
    send(3'd0, 3'd6, 4'd1, '0, 1'b0, "R3");
    expect_msg(4'd4, 3'd3, 3'd3, 4'd2, 4'd1, '0, "R6");
    expect_msg(4'd7, 3'd2, 3'd3, 4'd0, 4'd1, '0, "R6");
    expect_msg(4'd7, 3'd6, 3'd3, 4'd0, 4'd1, '0, "R6");
    send(3'd2, 3'd3, 4'd1, '0, 1'b0, "R6");
    expect_msg(4'd0, 3'd4, 3'd4, 4'd0, 4'd1, '0, "R5");
    send(3'd2, 3'd4, 4'd1, '0, 1'b0, "R5");
    expect_msg(4'd0, 3'd2, 3'd2, 4'd0, 4'd1, '0, "R7");
    send(3'd3, 3'd2, 4'd1, 32'h2222, 1'b0, "R7");
    expect_msg(4'd8, 3'd3, 3'd3, 4'd0, 4'd1, '0, "R7");
    send(3'd3, 3'd3, 4'd1, 32'h1234, 1'b1, "R7");
    expect_msg(4'd0, 3'd5, 3'd5, 4'd0, 4'd1, '0, "R5");
    send(3'd2, 3'd5, 4'd1, '0, 1'b0, "R5");
    expect_msg(4'd2, 3'd5, 3'd5, 4'd0, 4'd1, mword(4'd1), "R7");
    send(3'd0, 3'd5, 4'd1, '0, 1'b0, "R7");

    // line 2: writeback crossing a shared intervention
    expect_msg(4'd2, 3'd1, 3'd1, 4'd0, 4'd2, mword(4'd2), "R3");
    send(3'd1, 3'd1, 4'd2, '0, 1'b0, "R3");
    expect_msg(4'd3, 3'd4, 3'd4, 4'd0, 4'd2, mword(4'd2), "R4");
    expect_msg(4'd5, 3'd1, 3'd4, 4'd0, 4'd2, '0, "R4");
    send(3'd0, 3'd4, 4'd2, '0, 1'b0, "R4");
    expect_msg(4'd1, 3'd4, 3'd4, 4'd0, 4'd2, 32'h55, "R8");
    expect_msg(4'd8, 3'd1, 3'd1, 4'd0, 4'd2, '0, "R8");
    send(3'd3, 3'd1, 4'd2, 32'h55, 1'b1, "R8");
    expect_msg(4'd2, 3'd6, 3'd6, 4'd1, 4'd2, mword(4'd2), "R8");
    expect_msg(4'd7, 3'd4, 3'd6, 4'd0, 4'd2, '0, "R8");
    send(3'd1, 3'd6, 4'd2, '0, 1'b0, "R8");

    // line 3: writeback crossing an exclusive intervention, then downgrade
    expect_msg(4'd2, 3'd0, 3'd0, 4'd0, 4'd3, mword(4'd3), "R3");
    send(3'd0, 3'd0, 4'd3, '0, 1'b0, "R3");
    expect_msg(4'd3, 3'd7, 3'd7, 4'd0, 4'd3, mword(4'd3), "R4");
    expect_msg(4'd6, 3'd0, 3'd7, 4'd0, 4'd3, '0, "R4");
    send(3'd1, 3'd7, 4'd3, '0, 1'b0, "R4");
    expect_msg(4'd2, 3'd7, 3'd7, 4'd0, 4'd3, 32'h77, "R8");
    expect_msg(4'd8, 3'd0, 3'd0, 4'd0, 4'd3, '0, "R8");
    send(3'd3, 3'd0, 4'd3, 32'h77, 1'b1, "R8");
    expect_msg(4'd3, 3'd1, 3'd1, 4'd0, 4'd3, mword(4'd3), "R8");
    expect_msg(4'd5, 3'd7, 3'd1, 4'd0, 4'd3, '0, "R8");
    send(3'd0, 3'd1, 4'd3, '0, 1'b0, "R8");
    send(3'd5, 3'd7, 4'd3, 32'h0, 1'b0, "R9");
    expect_msg(4'd2, 3'd2, 3'd2, 4'd2, 4'd3, mword(4'd3), "R9");
    expect_msg(4'd7, 3'd1, 3'd2, 4'd0, 4'd3, '0, "R9");
    expect_msg(4'd7, 3'd7, 3'd2, 4'd0, 4'd3, '0, "R9");
    send(3'd1, 3'd2, 4'd3, '0, 1'b0, "R9");

    // line 4: ownership transfer
    expect_msg(4'd2, 3'd3, 3'd3, 4'd0, 4'd4, mword(4'd4), "R3");
    send(3'd1, 3'd3, 4'd4, '0, 1'b0, "R3");
    expect_msg(4'd3, 3'd5, 3'd5, 4'd0, 4'd4, mword(4'd4), "R4");
    expect_msg(4'd6, 3'd3, 3'd5, 4'd0, 4'd4, '0, "R4");
    send(3'd1, 3'd5, 4'd4, '0, 1'b0, "R4");
    send(3'd6, 3'd3, 4'd4, 32'h0, 1'b0, "R9");
    expect_msg(4'd3, 3'd6, 3'd6, 4'd0, 4'd4, mword(4'd4), "R9");
    expect_msg(4'd5, 3'd5, 3'd6, 4'd0, 4'd4, '0, "R9");
    send(3'd0, 3'd6, 4'd4, '0, 1'b0, "R9");

    // line 5: poisoned
    send(3'd7, 3'd0, 4'd5, '0, 1'b0, "R10");
    expect_msg(4'd9, 3'd1, 3'd1, 4'd0, 4'd5, '0, "R10");
    send(3'd0, 3'd1, 4'd5, '0, 1'b0, "R10");
    expect_msg(4'd9, 3'd2, 3'd2, 4'd0, 4'd5, '0, "R10");
    send(3'd3, 3'd2, 4'd5, 32'h99, 1'b0, "R10");
    expect_msg(4'd9, 3'd4, 3'd4, 4'd0, 4'd5, '0, "R10");
    send(3'd1, 3'd4, 4'd5, '0, 1'b0, "R10");

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12", "all expected messages seen", 64'(exp_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule